// File: doc/BRIEF.md
# Presettable Up/Down Counter Stage with Cascade Enables

This block is a synchronous binary counter slice, four bits wide by default, that counts up or down and wraps at its modulus. On every rising clock edge it does exactly one of five things: it clears, it loads a preset word, it increments, it decrements, or it holds. There are two count enables, both active low. The parallel enable is meant to be shared by every slice of a wider counter. The chain enable is meant to be driven by the previous slice.

The terminal-count output is active low and is decoded combinationally. It goes low when the chain enable is active and the state sits at the boundary value for the selected direction: all ones when counting up, zero when counting down. The parallel enable has no part in that decode. To build a wider counter, feed each slice's terminal count into the next slice's chain enable, and share the clock, the preset control and the parallel enable across all slices. N slices then form one 4N-bit synchronous counter with no ripple through the clocks. Terminal count can glitch, so it must never be used as a clock.

The operation is chosen by a small decoder. Its named outcomes are OP_CLEAR, OP_LOAD, OP_INC, OP_DEC and OP_HOLD. The decoder checks the inputs in a fixed order: reset first, then preset, then the two enables together with direction. The state register moves from its present value to the value produced by the selected operation:
- OP_CLEAR goes to 0.
- OP_LOAD goes to the data word.
- OP_INC goes to state+1.
- OP_DEC goes to state-1.
- OP_HOLD keeps the same value.

Top module: `bidir_preset_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes 0 on that edge, whatever the other inputs are, including `load_n` low.
- R2: When `rst` is low and `load_n` is low at a rising edge, `q` takes `din` on that edge, ignoring both enables and `up`.
- R3: When `rst` is low, `load_n` is high, both enables are low and `up` is 1, `q` becomes `q`+1 modulo 2^W, so 15 goes to 0.
- R4: Under the same conditions with `up` at 0, `q` becomes `q`-1 modulo 2^W, so 0 goes to 15.
- R5: When `rst` is low, `load_n` is high and either enable is high, `q` keeps its value.
- R6: `tc_n` is 0 exactly when `en_chain_n` is 0 and either `up` is 1 with `q` all ones, or `up` is 0 with `q` equal to zero. It follows its inputs in the same cycle, with no register on the path.
- R7: `en_par_n` has no effect on `tc_n`.
- R8: Three slices chained terminal count to chain enable, with shared clock, `load_n` and `en_par_n`, count as one 12-bit counter in both directions and wrap at 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, active high |
| load_n | input | 1 | Preset enable, active low |
| din | input | W | Preset data word |
| en_par_n | input | 1 | Shared count enable, active low |
| en_chain_n | input | 1 | Chained count enable, active low, gates terminal count |
| up | input | 1 | Direction: 1 increments, 0 decrements |
| q | output | W | Counter state |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
The assertions check every edge-by-edge state transition: clear, preset, increment, decrement and hold. They also check the terminal-count decode in every cycle. Only the bench scenarios can show the wider behaviour: that a chain of three slices carries and borrows correctly across slice boundaries and wraps at 4096, and that a toggle of the parallel enable while the state sits at its boundary leaves terminal count untouched. Random stimulus with a fixed seed covers the mixed operations, and directed cases cover the wraps and the priority of reset over preset.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    typedef enum logic [2:0] {
        OP_CLEAR = 3'd0,
        OP_LOAD  = 3'd1,
        OP_INC   = 3'd2,
        OP_DEC   = 3'd3,
        OP_HOLD  = 3'd4
    } op_t;
endpackage

// File: rtl/bpc_op_select.sv
module bpc_op_select
    import bpc_pkg::*;
(
    input  logic rst,
    input  logic load_n,
    input  logic en_par_n,
    input  logic en_chain_n,
    input  logic up,
    output op_t  op
);
    // Fixed priority: clear, then preset, then counting, else hold
    always_comb begin
        if (rst)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (!en_par_n && !en_chain_n)
            op = up ? OP_INC : OP_DEC;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/bpc_next_value.sv
module bpc_next_value
    import bpc_pkg::*;
#(
    parameter int W = 4
) (
    input  op_t          op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_INC:   nxt = cur + ONE;
            OP_DEC:   nxt = cur - ONE;
            OP_HOLD:  nxt = cur;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bpc_terminal.sv
module bpc_terminal #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         en_chain_n,
    output logic         tc_n
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic at_edge;
    always_comb begin
        at_edge = up ? (cur == TOP) : (cur == '0);
        tc_n    = ~(at_edge & ~en_chain_n);
    end
endmodule

// File: rtl/bidir_preset_counter.sv
module bidir_preset_counter
    import bpc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_par_n,
    input  logic         en_chain_n,
    input  logic         up,
    output logic [W-1:0] q,
    output logic         tc_n
);
    op_t          op;
    logic [W-1:0] state_q;
    logic [W-1:0] state_d;
    logic         tc_raw;

    bpc_op_select u_sel (
        .rst        (rst),
        .load_n     (load_n),
        .en_par_n   (en_par_n),
        .en_chain_n (en_chain_n),
        .up         (up),
        .op         (op)
    );

    bpc_next_value #(.W(W)) u_nxt (
        .op  (op),
        .cur (state_q),
        .din (din),
        .nxt (state_d)
    );

    bpc_terminal #(.W(W)) u_tc (
        .cur        (state_q),
        .up         (up),
        .en_chain_n (en_chain_n),
        .tc_n       (tc_raw)
    );

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        q    = state_q;
        tc_n = tc_raw;
    end
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         en_par_n,
    input logic         en_chain_n,
    input logic         up,
    input logic [W-1:0] q,
    input logic         tc_n
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TOP = {W{1'b1}};

    p_clear_r1: assert property (@(posedge clk) rst |=> (q == '0));

    p_preset_r2: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> (q == $past(din)));

    p_inc_r3: assert property (@(posedge clk) disable iff (rst)
        (load_n && !en_par_n && !en_chain_n && up) |=> (q == $past(q) + ONE));

    p_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (load_n && !en_par_n && !en_chain_n && !up) |=> (q == $past(q) - ONE));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (load_n && (en_par_n || en_chain_n)) |=> $stable(q));

    p_tc_chain_gate_r6: assert property (@(posedge clk) disable iff (rst)
        en_chain_n |-> tc_n);

    p_tc_up_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (!en_chain_n && up && q == TOP) |-> !tc_n);

    p_tc_down_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (!en_chain_n && !up && q == '0) |-> !tc_n);

    p_tc_only_edge_r7: assert property (@(posedge clk) disable iff (rst)
        !tc_n |-> (up ? (q == TOP) : (q == '0)));
endmodule

bind bidir_preset_counter bpc_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_n     (load_n),
    .din        (din),
    .en_par_n   (en_par_n),
    .en_chain_n (en_chain_n),
    .up         (up),
    .q          (q),
    .tc_n       (tc_n)
);

// File: tb/sim_bidir_preset_counter.sv
module sim_bidir_preset_counter;
    localparam int W  = 4;
    localparam int NS = 3;
    localparam int CW = W * NS;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int n_run  = 0;
    int n_fail = 0;

    // single stage
    logic         rst, load_n, en_par_n, en_chain_n, up;
    logic [W-1:0] din;
    logic [W-1:0] q;
    logic         tc_n;

    bidir_preset_counter #(.W(W)) u0 (
        .clk(clk), .rst(rst), .load_n(load_n), .din(din), .en_par_n(en_par_n),
        .en_chain_n(en_chain_n), .up(up), .q(q), .tc_n(tc_n)
    );

    // cascade of NS stages
    logic          c_rst, c_load_n, c_par_n, c_chain_n, c_up;
    logic [CW-1:0] c_din;
    logic [CW-1:0] c_q;
    logic [NS-1:0] c_tc;
    logic [NS-1:0] c_en;

    assign c_en[0] = c_chain_n;
    for (genvar g = 0; g < NS; g++) begin : g_st
        if (g > 0) begin : g_link
            assign c_en[g] = c_tc[g-1];
        end
        bidir_preset_counter #(.W(W)) u_s (
            .clk(clk), .rst(c_rst), .load_n(c_load_n), .din(c_din[g*W +: W]),
            .en_par_n(c_par_n), .en_chain_n(c_en[g]), .up(c_up),
            .q(c_q[g*W +: W]), .tc_n(c_tc[g])
        );
    end

    function automatic logic [W-1:0] f_next(logic [W-1:0] cur, logic r, logic ld_n,
                                           logic [W-1:0] d, logic p_n, logic c_n, logic u);
        if (r) return '0;
        if (!ld_n) return d;
        if (!p_n && !c_n) return u ? cur + 1'b1 : cur - 1'b1;
        return cur;
    endfunction

    function automatic logic f_tc(logic [W-1:0] cur, logic c_n, logic u);
        if (c_n) return 1'b1;
        return u ? !(cur == {W{1'b1}}) : !(cur == '0);
    endfunction

    function automatic string f_tag(logic r, logic ld_n, logic p_n, logic c_n, logic u);
        if (r) return "R1";
        if (!ld_n) return "R2";
        if (!p_n && !c_n) return u ? "R3" : "R4";
        return "R5";
    endfunction

    task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [W-1:0] mq;

    // Drive at negedge, check tc combinationally, check q at next negedge
    task automatic step(logic r, logic ld_n, logic [W-1:0] d, logic p_n, logic c_n, logic u);
        string tg;
        rst = r; load_n = ld_n; din = d; en_par_n = p_n; en_chain_n = c_n; up = u;
        #1;
        if (!r) check(en_par_n ? "R6/R7 tc" : "R6 tc", {{(CW-1){1'b0}}, tc_n},
                      {{(CW-1){1'b0}}, f_tc(mq, c_n, u)});
        tg = f_tag(r, ld_n, p_n, c_n, u);
        mq = f_next(mq, r, ld_n, d, p_n, c_n, u);
        @(posedge clk);
        @(negedge clk);
        check(tg, {{(CW-W){1'b0}}, q}, {{(CW-W){1'b0}}, mq});
    endtask

    logic [CW-1:0] mc;

    task automatic cstep(logic ld_n, logic [CW-1:0] d, logic p_n, logic c_n, logic u);
        logic exp_tc;
        c_rst = 1'b0; c_load_n = ld_n; c_din = d; c_par_n = p_n; c_chain_n = c_n; c_up = u;
        #1;
        exp_tc = c_n ? 1'b1 : (u ? !(mc == {CW{1'b1}}) : !(mc == '0));
        check("R8 chain tc", {{(CW-1){1'b0}}, c_tc[NS-1]}, {{(CW-1){1'b0}}, exp_tc});
        if (!ld_n) mc = d;
        else if (!p_n && !c_n) mc = u ? mc + 1'b1 : mc - 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 chain q", c_q, mc);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        rst = 1'b1; load_n = 1'b1; din = '0; en_par_n = 1'b1; en_chain_n = 1'b1; up = 1'b1;
        c_rst = 1'b1; c_load_n = 1'b1; c_din = '0; c_par_n = 1'b1; c_chain_n = 1'b1; c_up = 1'b1;
        mq = '0; mc = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", {{(CW-W){1'b0}}, q}, '0);
        check("R1 cascade reset", c_q, '0);

        // R1 beats preset
        mq = 4'h9;
        step(1'b0, 1'b0, 4'h9, 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 4'h6, 1'b0, 1'b0, 1'b1);
        // R3 wrap 15 -> 0
        step(1'b0, 1'b0, 4'hE, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
        // R4 wrap 0 -> 15
        step(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0);
        // R2 preset ignores enables and direction
        step(1'b0, 1'b0, 4'h5, 1'b0, 1'b0, 1'b0);
        // R7: at 15 counting up, chain active, par toggles -> tc_n stays 0, q held
        step(1'b0, 1'b0, 4'hF, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 4'h3, 1'b1, 1'b0, 1'b1);
        check("R7 par high tc", {{(CW-1){1'b0}}, tc_n}, '0);
        step(1'b0, 1'b1, 4'h3, 1'b1, 1'b0, 1'b1);
        // R6 chain high masks tc; R5 hold
        step(1'b0, 1'b1, 4'h3, 1'b0, 1'b1, 1'b1);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic r, ld;
            r  = ($urandom_range(31) == 0);
            ld = ($urandom_range(5) != 0);
            step(r, ld, W'($urandom), logic'($urandom_range(3) == 0),
                 logic'($urandom_range(3) == 0), logic'($urandom));
        end

        // cascade: clear, then directed wraps
        c_rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mc = '0;
        cstep(1'b0, 12'hFFC, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) cstep(1'b1, '0, 1'b0, 1'b0, 1'b1);
        cstep(1'b0, 12'h103, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) cstep(1'b1, '0, 1'b0, 1'b0, 1'b0);
        cstep(1'b0, 12'h002, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) cstep(1'b1, '0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) begin
            cstep(logic'($urandom_range(9) != 0), CW'($urandom),
                  logic'($urandom_range(4) == 0), logic'($urandom_range(4) == 0),
                  logic'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule